// File: doc/BRIEF.md
# Supervisory Reset Pulse Controller

This block creates the processor reset for a system. It takes two requests: a one-bit flag that says the supply is below its tolerance level, and a pushbutton input that reads low while pressed. It drives two reset outputs that always switch together. `rst_o` is active high and `rst_n_o` is active low.

Reset is asserted as soon as either request is seen. It stays asserted while the request remains, and then for a fixed minimum hold interval afterwards. The pushbutton is debounced, so a press or release only counts once it has been stable for a whole debounce window. Because the button holds the hold timer at zero while it is pressed, the minimum pulse is measured from the release, not from the press. The same timer also runs one full interval after the asynchronous power-on initialisation.

All timing is counted in clock cycles. The cycle counts are derived from a clock-frequency parameter and two millisecond parameters, so a bench can use small values.

Top module: `rst_supervisor`

## Requirements
- R1: When `supply_low_i` goes high, `rst_o` is high after the third rising clock edge that follows, and it stays high while `supply_low_i` stays high.
- R2: After `supply_low_i` returns low, with no other request pending, `rst_o` falls at rising edge HOLD+2 counted from that change. HOLD = CLK_HZ/1000*HOLD_MS cycles, and the synchronizer has its default depth of 2.
- R3: A low level on `pb_n_i` that lasts fewer than DB cycles has no effect on the outputs. DB = CLK_HZ/1000*DEBOUNCE_MS. Chatter before a stable level also has no effect, so the press timing is taken from the last edge of the chatter.
- R4: A press on `pb_n_i` (level 0) that stays stable makes `rst_o` rise at rising edge DB+3 counted from the start of the press.
- R5: `rst_o` stays high for as long as the button is held, however long that is. After release (level 1), `rst_o` falls at rising edge DB+2+HOLD counted from the release.
- R6: `rst_n_o` is always the inverse of `rst_o`.
- R7: `rst_o` is high while `arst_n` is low. With no request pending, `rst_o` falls at rising edge HOLD+2 after `arst_n` is released.
- R8: A new supply-low or button request that arrives during a hold interval keeps reset asserted. The hold count then starts again from zero once that request clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock the block runs on |
| arst_n | input | 1 | Asynchronous power-on initialisation, active low |
| supply_low_i | input | 1 | Supply below tolerance flag, active high, may be asynchronous |
| pb_n_i | input | 1 | Raw pushbutton level, 0 while pressed |
| rst_o | output | 1 | Reset to the processor, active high |
| rst_n_o | output | 1 | Reset to the processor, active low |

## Verification
Some properties are checked by assertions on every cycle. A pending request always forces reset on the next edge. The hold counter never goes past its limit. Reset is only released on the terminal count with no request present. The debounced level only moves after a full window of disagreement. The scenarios cover what a single-cycle property cannot show: the exact latency from each input edge to each output edge, the rejection of short presses and chatter, the timing of a very long press measured from its release, and the restart of the hold interval when a request arrives mid-interval.

// File: rtl/rst_sup_pkg.sv
`timescale 1ns/1ps
package rst_sup_pkg;
   // Converts a time in milliseconds into a count of clock cycles.
   function automatic longint unsigned ms_to_cycles(input longint unsigned clk_hz,
                                                    input longint unsigned ms);
      return (clk_hz / 1000) * ms;
   endfunction

   // Width of a counter that must hold values 0 .. n-1.
   function automatic int unsigned cnt_width(input longint unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rst_sync.sv
`timescale 1ns/1ps
module rst_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int unsigned CW = W * STAGES;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("rst_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [CW-1:0] chain;

   generate
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain <= {2{RST_VAL}};
            else         chain <= {chain[W-1:0], d};
         end
      end else begin : g_deep
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain <= {STAGES{RST_VAL}};
            else         chain <= {chain[CW-W-1:0], d};
         end
      end
   endgenerate

   assign q = chain[CW-1 -: W];
endmodule

// File: rtl/rst_debounce.sv
`timescale 1ns/1ps
module rst_debounce #(
   parameter longint unsigned CYC = 10,
   parameter logic            RST_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic arst_n,
   input  logic raw,
   output logic level
);
   localparam int unsigned CW = rst_sup_pkg::cnt_width(CYC);
   localparam logic [CW-1:0] LAST = CW'(CYC - 1);

   generate
      if (CYC < 1) begin : g_bad_window
         $error("rst_debounce: window must be at least one cycle");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         level <= RST_LEVEL;
         cnt   <= '0;
      end else if (raw == level) begin
         cnt <= '0;
      end else if (cnt == LAST) begin
         level <= raw;
         cnt   <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R3: the level only moves once the input has disagreed for a full window
   assert_window_full_R3: assert property (@(posedge clk) disable iff (!arst_n)
      (level != $past(level)) |-> ($past(cnt) == LAST));
   // R3: while input and level agree, the level stays where it is
   assert_agree_stable_R3: assert property (@(posedge clk) disable iff (!arst_n)
      (raw == level) |=> $stable(level));
   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!arst_n)
      cnt <= LAST);
endmodule

// File: rtl/rst_hold_timer.sv
`timescale 1ns/1ps
module rst_hold_timer #(
   parameter longint unsigned HOLD_CYC = 130
) (
   input  logic clk,
   input  logic arst_n,
   input  logic req,
   output logic active
);
   localparam int unsigned CW = rst_sup_pkg::cnt_width(HOLD_CYC);
   localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("rst_hold_timer: hold interval must be at least one cycle");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         active <= 1'b1;
         cnt    <= '0;
      end else if (req) begin
         active <= 1'b1;
         cnt    <= '0;
      end else if (active) begin
         if (cnt == LAST) begin
            active <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R1: any pending request asserts reset on the next edge
   assert_req_forces_rst_R1: assert property (@(posedge clk) disable iff (!arst_n)
      req |=> active);
   // R8: a request restarts the hold count
   assert_req_clears_cnt_R8: assert property (@(posedge clk) disable iff (!arst_n)
      req |=> (cnt == '0));
   // R2: release only on the terminal count with no request seen
   assert_release_at_end_R2: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(active) |-> ($past(cnt) == LAST && !$past(req)));
   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!arst_n)
      cnt <= LAST);
endmodule

// File: rtl/rst_supervisor.sv
`timescale 1ns/1ps
module rst_supervisor #(
   parameter longint unsigned CLK_HZ      = 50_000_000,
   parameter longint unsigned HOLD_MS     = 130,
   parameter longint unsigned DEBOUNCE_MS = 10,
   parameter int unsigned     SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic supply_low_i,
   input  logic pb_n_i,
   output logic rst_o,
   output logic rst_n_o
);
   localparam longint unsigned HOLD_CYC = rst_sup_pkg::ms_to_cycles(CLK_HZ, HOLD_MS);
   localparam longint unsigned DB_CYC   = rst_sup_pkg::ms_to_cycles(CLK_HZ, DEBOUNCE_MS);

   generate
      if (CLK_HZ < 1000) begin : g_bad_clk
         $error("rst_supervisor: CLK_HZ must be at least 1000");
      end
   endgenerate

   logic [1:0] raw_s;
   logic       supply_low_s;
   logic       pb_n_s;
   logic       pb_n_db;
   logic       hold_req;
   logic       rst_q;

   rst_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .d      ({supply_low_i, pb_n_i}),
      .q      (raw_s)
   );

   assign supply_low_s = raw_s[1];
   assign pb_n_s       = raw_s[0];

   rst_debounce #(.CYC(DB_CYC), .RST_LEVEL(1'b1)) u_db (
      .clk    (clk),
      .arst_n (arst_n),
      .raw    (pb_n_s),
      .level  (pb_n_db)
   );

   assign hold_req = supply_low_s | ~pb_n_db;

   rst_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk    (clk),
      .arst_n (arst_n),
      .req    (hold_req),
      .active (rst_q)
   );

   assign rst_o   = rst_q;
   assign rst_n_o = ~rst_q;

   // R1: a synchronized supply-low flag never coexists with released reset a cycle later
   assert_supply_holds_rst_R1: assert property (@(posedge clk) disable iff (!arst_n)
      supply_low_s |=> rst_o);
   // R5: a debounced press keeps reset asserted
   assert_press_holds_rst_R5: assert property (@(posedge clk) disable iff (!arst_n)
      !pb_n_db |=> rst_o);
endmodule

// File: tb/sim_rst_supervisor.sv
`timescale 1ns/1ps
module sim_rst_supervisor;
   localparam int HOLD = 130;
   localparam int DB   = 10;

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   logic supply_low_i = 1'b0;
   logic pb_n_i = 1'b1;
   logic rst_o, rst_n_o;

   int n_run = 0;
   int n_fail = 0;
   int comp_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rst_supervisor #(.CLK_HZ(1000), .HOLD_MS(HOLD), .DEBOUNCE_MS(DB)) u0 (
      .clk(clk), .arst_n(arst_n), .supply_low_i(supply_low_i),
      .pb_n_i(pb_n_i), .rst_o(rst_o), .rst_n_o(rst_n_o)
   );

   always @(negedge clk) if (rst_n_o !== ~rst_o) comp_err++;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Counts rising edges after a negedge stimulus until rst_o equals want.
   task automatic meas(input logic want, input int lim, output int n);
      n = 0;
      do begin
         @(posedge clk); n++;
         @(negedge clk);
      end while (rst_o !== want && n < lim);
   endtask

   task automatic idle(input int c);
      repeat (c) @(negedge clk);
   endtask

   task automatic t_power_on;
      int n;
      idle(3);
      check(rst_o === 1'b1, "R7", "rst_o during arst", rst_o, 1);
      check(rst_n_o === 1'b0, "R6", "rst_n_o during arst", rst_n_o, 0);
      arst_n = 1'b1;
      meas(1'b0, 4 * HOLD, n);
      check(n == HOLD + 2, "R7", "edges to release after power-on", n, HOLD + 2);
   endtask

   task automatic t_supply;
      int n;
      int drop = 0;
      idle(5);
      supply_low_i = 1'b1;
      meas(1'b1, 20, n);
      check(n == 3, "R1", "edges to assert on supply low", n, 3);
      for (int i = 0; i < 3 * HOLD; i++) begin
         @(negedge clk);
         if (rst_o !== 1'b1) drop++;
      end
      check(drop == 0, "R1", "cycles released while supply low", drop, 0);
      supply_low_i = 1'b0;
      meas(1'b0, 4 * HOLD, n);
      check(n == HOLD + 2, "R2", "edges to release after supply ok", n, HOLD + 2);
   endtask

   task automatic t_glitch;
      int hi = 0;
      idle(5);
      pb_n_i = 1'b0;
      idle(DB - 1);
      pb_n_i = 1'b1;
      for (int i = 0; i < 4 * DB; i++) begin
         @(negedge clk);
         if (rst_o !== 1'b0) hi++;
      end
      check(hi == 0, "R3", "cycles asserted after short press", hi, 0);
   endtask

   task automatic t_press_long;
      int n;
      int drop = 0;
      idle(5);
      pb_n_i = 1'b0;
      meas(1'b1, 4 * DB, n);
      check(n == DB + 3, "R4", "edges to assert on press", n, DB + 3);
      for (int i = 0; i < 3 * HOLD; i++) begin
         @(negedge clk);
         if (rst_o !== 1'b1) drop++;
      end
      check(drop == 0, "R5", "cycles released while held", drop, 0);
      pb_n_i = 1'b1;
      meas(1'b0, 4 * HOLD, n);
      check(n == DB + 2 + HOLD, "R5", "edges to release after button up", n, DB + 2 + HOLD);
   endtask

   task automatic t_chatter;
      int n;
      idle(5);
      for (int i = 0; i < 6; i++) begin
         pb_n_i = ~pb_n_i;
         idle(3);
      end
      check(rst_o === 1'b0, "R3", "rst_o during chatter", rst_o, 0);
      pb_n_i = 1'b0;
      meas(1'b1, 4 * DB, n);
      check(n == DB + 3, "R3", "press timed from end of chatter", n, DB + 3);
      pb_n_i = 1'b1;
      meas(1'b0, 4 * HOLD, n);
      check(n == DB + 2 + HOLD, "R5", "release after chatter press", n, DB + 2 + HOLD);
   endtask

   task automatic t_retrigger;
      int n;
      idle(5);
      supply_low_i = 1'b1;
      idle(5);
      supply_low_i = 1'b0;
      idle(HOLD / 2);
      check(rst_o === 1'b1, "R8", "rst_o mid hold", rst_o, 1);
      supply_low_i = 1'b1;
      idle(5);
      supply_low_i = 1'b0;
      meas(1'b0, 4 * HOLD, n);
      check(n == HOLD + 2, "R8", "hold restarts after second supply dip", n, HOLD + 2);
      pb_n_i = 1'b0;
      idle(DB + 5);
      pb_n_i = 1'b1;
      idle(HOLD / 2);
      pb_n_i = 1'b0;
      idle(DB + 5);
      check(rst_o === 1'b1, "R8", "rst_o on second press", rst_o, 1);
      pb_n_i = 1'b1;
      meas(1'b0, 4 * HOLD, n);
      check(n == DB + 2 + HOLD, "R8", "hold restarts after second press", n, DB + 2 + HOLD);
   endtask

   initial begin
      t_power_on();
      t_supply();
      t_glitch();
      t_press_long();
      t_chatter();
      t_retrigger();
      check(comp_err == 0, "R6", "complement mismatches", comp_err, 0);
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule